// File: doc/BRIEF.md
# FFT Vector Permutation Unit

This block reorders the elements of a 64-element vector, or of a 128-element pair of vectors, to serve the data-movement steps of a radix-2 FFT. It offers three bit-reversal permutations, which work inside aligned groups of 16, 32 or 64 elements, and two perfect shuffles, which work inside groups of 32 or 64 elements. It also has a 128-element shuffle across a vector pair and the exact inverse of that shuffle. The 128-element unshuffle turns interleaved real/imaginary data back into two separate vectors.

The caller supplies four things:
- the source vector pair;
- the current contents of the destination pair;
- a 3-bit operation code;
- an inclusive element range given by a low and a high bound.

The result is registered. Elements outside the range, and the upper vector for the 64-element operations, keep their current destination value. A range that the chosen operation does not accept raises an error flag and returns the destination unchanged. Choosing the even-numbered register of a pair is left to the caller: the pair arrives already split into a lower and an upper vector.

Top module: `fftperm_top`

## Requirements
- R1: After a synchronous active-low reset, `res_lo`, `res_hi`, `out_valid` and `range_err` are all zero.
- R2: Op 2 (64-point bit reverse) accepts only the range 0..63. Lower-vector destination element with index bits b5..b0 takes source element b0..b5.
- R3: Op 1 (32-point bit reverse) accepts the ranges 0..31, 32..63 and 0..63. Inside each half, index bit 5 is kept and bits 4..0 are reversed.
- R4: Op 0 (16-point bit reverse) accepts any range from 16k to 16m+15 with k <= m. Inside each quarter the low four index bits are reversed, so a quarter holding 0..15 reads 0 8 4 12 2 10 6 14 1 9 5 13 3 11 7 15.
- R5: Op 3 (32-point shuffle) and op 4 (64-point shuffle) accept the same ranges as ops 1 and 2. Each group's output alternates elements from its first and second halves, starting with the first half. For 32 elements this gives 0 16 1 17 ... 15 31.
- R6: Op 5 (128-point shuffle) accepts only 0..63. It treats `src_lo` as elements 0..63 and `src_hi` as elements 64..127. Output element 2k takes element k and output element 2k+1 takes element 64+k, across `res_lo` then `res_hi`.
- R7: Op 6 (128-point unshuffle) is the exact inverse of op 5. Output element k takes element 2k and output element 64+k takes element 2k+1.
- R8: Lower-vector elements outside the range keep `cur_lo`. For ops 0 to 4, `res_hi` equals `cur_hi`.
- R9: Op 7, or a range that the operation does not accept, sets `range_err` with `out_valid`. In that case `res_lo`/`res_hi` equal `cur_lo`/`cur_hi`.
- R10: Results appear in the cycle after `in_valid`. `out_valid` is high for exactly one cycle per request. Outputs hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| rng_lo | input | 6 | Range low bound |
| rng_hi | input | 6 | Range high bound |
| src_lo | input | 64*ELEM_W | Source vector, elements 0..63 |
| src_hi | input | 64*ELEM_W | Source pair upper vector |
| cur_lo | input | 64*ELEM_W | Current destination vector |
| cur_hi | input | 64*ELEM_W | Current destination pair upper vector |
| out_valid | output | 1 | Result strobe |
| range_err | output | 1 | Rejected range or operation |
| res_lo | output | 64*ELEM_W | Result vector |
| res_hi | output | 64*ELEM_W | Result pair upper vector |

## Verification
Permutation and range retention act in the same cycle whenever a partial range is chosen. The result vector then mixes permuted elements with kept destination elements, and a wrong group boundary shows up as a misplaced or overwritten element. The bench provokes this with random legal sub-ranges over random source and destination contents. It judges every element against a scatter-based model that moves each in-range source element to its destination.

The second overlap is error detection against the write. Random illegal bounds, and op 7, are mixed among legal requests. These must leave both output vectors equal to the destination inputs of that request.

// File: rtl/fftperm_pkg.sv
// Package: operation codes and the per-element source index map shared by
// the permutation datapath. Assumes a fixed 64-element vector (6 index bits).
package fftperm_pkg;

    localparam int VEC_N   = 64;
    localparam int IDX_W   = 6;
    localparam int PAIR_N  = 2 * VEC_N;
    localparam int PIDX_W  = IDX_W + 1;

    typedef enum logic [2:0] {
        OP_BREV16  = 3'd0,
        OP_BREV32  = 3'd1,
        OP_BREV64  = 3'd2,
        OP_SHUF32  = 3'd3,
        OP_SHUF64  = 3'd4,
        OP_SHUF128 = 3'd5,
        OP_UNSH128 = 3'd6,
        OP_RSVD    = 3'd7
    } perm_op_e;

    // Source position (0..127 over the concatenated pair) feeding output position p.
    function automatic logic [PIDX_W-1:0] gather_index(perm_op_e sel, logic [PIDX_W-1:0] p);
        logic [PIDX_W-1:0] r;
        case (sel)
            OP_BREV16:  r = {1'b0, p[5], p[4], p[0], p[1], p[2], p[3]};
            OP_BREV32:  r = {1'b0, p[5], p[0], p[1], p[2], p[3], p[4]};
            OP_BREV64:  r = {1'b0, p[0], p[1], p[2], p[3], p[4], p[5]};
            OP_SHUF32:  r = {1'b0, p[5], p[0], p[4:1]};
            OP_SHUF64:  r = {1'b0, p[0], p[5:1]};
            OP_SHUF128: r = {p[0], p[6:1]};
            OP_UNSH128: r = {p[5:0], p[6]};
            default:    r = p;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fftperm_range_chk.sv
// Range checker: decides whether (lo, hi) is an accepted range for the
// operation and builds the per-element write mask over the 128-element pair.
// Assumes lo/hi are 6-bit element indices; upper half is written only by
// the pair operations, which always cover the full range.
module fftperm_range_chk
    import fftperm_pkg::*;
(
    input  perm_op_e             op_i,
    input  logic [IDX_W-1:0]     lo_i,
    input  logic [IDX_W-1:0]     hi_i,
    output logic                 legal_o,
    output logic [PAIR_N-1:0]    wmask_o
);

    logic full_rng;
    logic half_rng;
    logic quarter_rng;
    logic pair_op;

    // Classify the bounds against the three subrange families.
    always_comb begin
        full_rng    = (lo_i == '0) && (hi_i == IDX_W'(VEC_N - 1));
        half_rng    = (lo_i[4:0] == 5'd0) && (hi_i[4:0] == 5'h1f) && (lo_i <= hi_i);
        quarter_rng = (lo_i[3:0] == 4'd0) && (hi_i[3:0] == 4'hf) && (lo_i <= hi_i);
        pair_op     = (op_i == OP_SHUF128) || (op_i == OP_UNSH128);
    end

    // Select the accepted family per operation.
    always_comb begin
        case (op_i)
            OP_BREV16:                       legal_o = quarter_rng;
            OP_BREV32, OP_SHUF32:            legal_o = half_rng;
            OP_BREV64, OP_SHUF64,
            OP_SHUF128, OP_UNSH128:          legal_o = full_rng;
            default:                         legal_o = 1'b0;
        endcase
    end

    genvar k;
    generate
        for (k = 0; k < VEC_N; k++) begin : g_lo_mask
            // Lower-vector element written when inside the bounds.
            assign wmask_o[k] = legal_o && (lo_i <= IDX_W'(k)) && (IDX_W'(k) <= hi_i);
        end
        for (k = VEC_N; k < PAIR_N; k++) begin : g_hi_mask
            // Upper-vector element written only by the pair operations.
            assign wmask_o[k] = legal_o && pair_op;
        end
    endgenerate

endmodule

// File: rtl/fftperm_xbar.sv
// Crossbar: for every output position of the 128-element pair, picks the
// source element given by the index map, or keeps the current destination
// element when the write mask bit is clear.
module fftperm_xbar
    import fftperm_pkg::*;
#(
    parameter int ELEM_W = 8,
    localparam int CAT_W = PAIR_N * ELEM_W
) (
    input  perm_op_e             op_i,
    input  logic [CAT_W-1:0]     src_i,
    input  logic [CAT_W-1:0]     cur_i,
    input  logic [PAIR_N-1:0]    wmask_i,
    output logic [CAT_W-1:0]     nxt_o
);

    genvar p;
    generate
        for (p = 0; p < PAIR_N; p++) begin : g_pos
            logic [PIDX_W-1:0] sidx;
            // Source lookup for this output position.
            assign sidx = gather_index(op_i, PIDX_W'(p));
            // Merge permuted element with kept destination element.
            assign nxt_o[p*ELEM_W +: ELEM_W] = wmask_i[p]
                ? src_i[sidx*ELEM_W +: ELEM_W]
                : cur_i[p*ELEM_W +: ELEM_W];
        end
    endgenerate

endmodule

// File: rtl/fftperm_top.sv
// FFT permutation unit top: range check, crossbar, and one output register
// stage. A request on in_valid produces a one-cycle out_valid pulse on the
// next cycle; a rejected request returns the destination unchanged.
module fftperm_top
    import fftperm_pkg::*;
#(
    parameter int ELEM_W = 8,
    localparam int VEC_W = VEC_N * ELEM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         op,
    input  logic [IDX_W-1:0]   rng_lo,
    input  logic [IDX_W-1:0]   rng_hi,
    input  logic [VEC_W-1:0]   src_lo,
    input  logic [VEC_W-1:0]   src_hi,
    input  logic [VEC_W-1:0]   cur_lo,
    input  logic [VEC_W-1:0]   cur_hi,
    output logic               out_valid,
    output logic               range_err,
    output logic [VEC_W-1:0]   res_lo,
    output logic [VEC_W-1:0]   res_hi
);

    perm_op_e             op_e;
    logic                 legal;
    logic [PAIR_N-1:0]    wmask;
    logic [2*VEC_W-1:0]   nxt_cat;

    // Decode the raw op code into the enumerated type.
    assign op_e = perm_op_e'(op);

    fftperm_range_chk u_rng (
        .op_i    (op_e),
        .lo_i    (rng_lo),
        .hi_i    (rng_hi),
        .legal_o (legal),
        .wmask_o (wmask)
    );

    fftperm_xbar #(.ELEM_W(ELEM_W)) u_xbar (
        .op_i    (op_e),
        .src_i   ({src_hi, src_lo}),
        .cur_i   ({cur_hi, cur_lo}),
        .wmask_i (wmask),
        .nxt_o   (nxt_cat)
    );

    // Output register: capture result and flags on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            range_err <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
        end else begin
            out_valid <= in_valid;
            range_err <= in_valid && !legal;
            if (in_valid) begin
                res_lo <= nxt_cat[VEC_W-1:0];
                res_hi <= nxt_cat[2*VEC_W-1:VEC_W];
            end
        end
    end

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));
    a_r9_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> out_valid);
    a_r9_rsvd_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7) |=> range_err);
    a_r9_err_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 3'd7 && rng_lo > rng_hi) |=>
            (res_lo == $past(cur_lo) && res_hi == $past(cur_hi)));
    a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op < 3'd5) |=> (res_hi == $past(cur_hi)));

endmodule

// File: tb/fftperm_top_tb.sv
module fftperm_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int N  = 64;
    localparam int VW = N * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [2:0]    op;
    logic [5:0]    rng_lo, rng_hi;
    logic [VW-1:0] src_lo, src_hi, cur_lo, cur_hi;
    logic          out_valid, range_err;
    logic [VW-1:0] res_lo, res_hi;

    int n_checks = 0;
    int n_errs   = 0;

    logic [W-1:0] s_a [128];
    logic [W-1:0] c_a [128];
    logic [W-1:0] x_a [128];
    logic         x_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    fftperm_top #(.ELEM_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .rng_lo(rng_lo), .rng_hi(rng_hi),
        .src_lo(src_lo), .src_hi(src_hi), .cur_lo(cur_lo), .cur_hi(cur_hi),
        .out_valid(out_valid), .range_err(range_err),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    function automatic string req_of(input logic [2:0] o, input logic bad);
        if (bad) return "R9";
        case (o)
            3'd0: return "R4";
            3'd1: return "R3";
            3'd2: return "R2";
            3'd3, 3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic int rev_bits(input int v, input int nb);
        int r = 0;
        for (int b = 0; b < nb; b++) if (v & (1 << b)) r |= 1 << (nb - 1 - b);
        return r;
    endfunction

    function automatic logic legal_rng(input logic [2:0] o, input int lo, input int hi);
        case (o)
            3'd0: return (lo % 16 == 0) && (hi % 16 == 15) && (lo <= hi);
            3'd1, 3'd3: return (lo == 0 || lo == 32) && (hi == 31 || hi == 63) && (lo <= hi);
            3'd2, 3'd4, 3'd5, 3'd6: return (lo == 0) && (hi == 63);
            default: return 1'b0;
        endcase
    endfunction

    // Reference: scatter each in-range source element to its destination.
    task automatic model(input logic [2:0] o, input int lo, input int hi);
        int g, base, off, d;
        for (int i = 0; i < 128; i++) x_a[i] = c_a[i];
        x_err = !legal_rng(o, lo, hi);
        if (x_err) return;
        if (o == 3'd5) begin
            for (int j = 0; j < 128; j++) begin
                d = (j < 64) ? 2 * j : 2 * (j - 64) + 1;
                x_a[d] = s_a[j];
            end
        end else if (o == 3'd6) begin
            for (int j = 0; j < 128; j++) x_a[(j % 2 == 0) ? j / 2 : 64 + j / 2] = s_a[j];
        end else begin
            g = (o == 3'd0) ? 16 : (o == 3'd1 || o == 3'd3) ? 32 : 64;
            for (int j = lo; j <= hi; j++) begin
                base = j - (j % g);
                off  = j % g;
                if (o <= 3'd2) d = base + rev_bits(off, $clog2(g));
                else d = (off < g / 2) ? base + 2 * off : base + 2 * (off - g / 2) + 1;
                x_a[d] = s_a[j];
            end
        end
    endtask

    task automatic pack_inputs();
        for (int i = 0; i < N; i++) begin
            src_lo[i*W +: W] = s_a[i];
            src_hi[i*W +: W] = s_a[N + i];
            cur_lo[i*W +: W] = c_a[i];
            cur_hi[i*W +: W] = c_a[N + i];
        end
    endtask

    task automatic check_out(input string tag);
        int bad = 0;
        n_checks++;
        for (int i = 0; i < N; i++) begin
            if (res_lo[i*W +: W] !== x_a[i]) bad++;
            if (res_hi[i*W +: W] !== x_a[N + i]) bad++;
        end
        if (bad != 0 || out_valid !== 1'b1 || range_err !== x_err) begin
            n_errs++;
            $display("FAIL %s op=%0d lo=%0d hi=%0d: actual valid=%b err=%b mismatches=%0d expected valid=1 err=%b mismatches=0",
                     tag, op, rng_lo, rng_hi, out_valid, range_err, bad, x_err);
        end
    endtask

    // R10: one request -> one pulse; outputs hold afterwards.
    task automatic run_op(input logic [2:0] o, input int lo, input int hi);
        logic [VW-1:0] hold_lo, hold_hi;
        @(negedge clk);
        pack_inputs();
        op = o; rng_lo = 6'(lo); rng_hi = 6'(hi); in_valid = 1'b1;
        model(o, lo, hi);
        @(negedge clk);
        in_valid = 1'b0;
        check_out(req_of(o, x_err));
        hold_lo = res_lo; hold_hi = res_hi;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || res_lo !== hold_lo || res_hi !== hold_hi) begin
            n_errs++;
            $display("FAIL R10 pulse/hold: actual valid=%b held=%b expected valid=0 held=1",
                     out_valid, (res_lo === hold_lo && res_hi === hold_hi));
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 128; i++) begin
            s_a[i] = W'($urandom);
            c_a[i] = W'($urandom);
        end
    endtask

    task automatic fill_index();
        for (int i = 0; i < 128; i++) begin
            s_a[i] = W'(i);
            c_a[i] = W'(8'hEE);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++; n_checks++;
        $display("FAIL R10 watchdog: actual=hung expected=complete");
        finish_run();
    end

    initial begin
        int lo, hi, sel;
        logic [2:0] o;
        int exp16 [16] = '{0, 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7, 15};
        logic [W-1:0] keep [128];
        void'($urandom(32'd2024));
        rst_n = 1'b0; in_valid = 1'b0; op = '0; rng_lo = '0; rng_hi = '0;
        src_lo = '0; src_hi = '0; cur_lo = '1; cur_hi = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (out_valid !== 1'b0 || range_err !== 1'b0 || res_lo !== '0 || res_hi !== '0) begin
            n_errs++;
            $display("FAIL R1 reset: actual valid=%b err=%b lo_zero=%b hi_zero=%b expected 0 0 1 1",
                     out_valid, range_err, res_lo == '0, res_hi == '0);
        end
        rst_n = 1'b1;

        // R4: literal 16-point order in every quarter
        fill_index();
        run_op(3'd0, 0, 63);
        for (int q = 0; q < 4; q++) begin
            for (int i = 0; i < 16; i++) begin
                n_checks++;
                if (res_lo[(16*q+i)*W +: W] !== W'(16*q + exp16[i])) begin
                    n_errs++;
                    $display("FAIL R4 order pos=%0d: actual=%0d expected=%0d",
                             16*q+i, res_lo[(16*q+i)*W +: W], 16*q + exp16[i]);
                end
            end
        end
        // R5: literal 32-point shuffle order
        run_op(3'd3, 0, 31);
        for (int i = 0; i < 32; i++) begin
            n_checks++;
            if (res_lo[i*W +: W] !== W'((i % 2 == 0) ? i / 2 : 16 + i / 2)) begin
                n_errs++;
                $display("FAIL R5 order pos=%0d: actual=%0d expected=%0d",
                         i, res_lo[i*W +: W], (i % 2 == 0) ? i / 2 : 16 + i / 2);
            end
        end
        // R2, R3, R8: directed partial and full ranges
        run_op(3'd2, 0, 63);
        run_op(3'd1, 32, 63);
        run_op(3'd0, 16, 47);
        run_op(3'd4, 0, 63);
        // R9: rejected ranges and reserved op
        run_op(3'd2, 0, 31);
        run_op(3'd1, 16, 47);
        run_op(3'd0, 32, 15);
        run_op(3'd7, 0, 63);
        run_op(3'd5, 0, 62);
        // R6 then R7: round trip restores the original pair
        fill_random();
        for (int i = 0; i < 128; i++) keep[i] = s_a[i];
        run_op(3'd5, 0, 63);
        for (int i = 0; i < 128; i++) s_a[i] = x_a[i];
        run_op(3'd6, 0, 63);
        for (int i = 0; i < 128; i++) begin
            n_checks++;
            if (x_a[i] !== keep[i] || ((i < 64) ? res_lo[i*W +: W] : res_hi[(i-64)*W +: W]) !== keep[i]) begin
                n_errs++;
                $display("FAIL R7 round trip pos=%0d: actual=%0h expected=%0h",
                         i, (i < 64) ? res_lo[i*W +: W] : res_hi[(i-64)*W +: W], keep[i]);
            end
        end
        // Random mix of legal and illegal requests
        for (int t = 0; t < 400; t++) begin
            fill_random();
            o = 3'($urandom_range(0, 7));
            sel = $urandom_range(0, 3);
            if (sel == 0) begin
                lo = $urandom_range(0, 63); hi = $urandom_range(0, 63);
            end else if (o == 3'd0) begin
                lo = 16 * $urandom_range(0, 3); hi = 16 * $urandom_range(lo / 16, 3) + 15;
            end else if (o == 3'd1 || o == 3'd3) begin
                lo = 32 * $urandom_range(0, 1); hi = 32 * $urandom_range(lo / 32, 1) + 31;
            end else begin
                lo = 0; hi = 63;
            end
            run_op(o, lo, hi);
        end
        finish_run();
    end

endmodule